// File: doc/BRIEF.md
# Fast Ethernet PCS Carrier-Sense Receiver

This block sits on the receive side of a 100 Mb/s physical coding sublayer. It takes the descrambled code-bit stream, one bit per clock, and decides when a stream has begun. While the line is idle it sees a run of ones. The first zero bit fixes the 5-bit code-group boundary: that zero is taken as the third bit of a start delimiter. A second zero inside the same group declares carrier. From then on, carrier sense and the receiving flag are high while the block checks that the first two aligned groups form the start-of-stream delimiter.

If either delimiter group is wrong, the block reports a false carrier. It drops carrier, holds the receive error for one code-group period and then goes back to idle. A confirmed stream stays in the receive state until an end delimiter pair arrives. If the line returns to a run of ten ones first, the block ends the stream with an error. While carrier is up, every completed aligned group is presented with a one-clock strobe.

Top module: `pcs_carrier_sense`

## Requirements
- R1: A synchronous reset, taken mid-stream or at start-up, clears `crs`, `receiving`, `rx_er` and `grp_valid` after the next clock edge and fills `grp_data` with 5'b11111. The block then detects the next stream normally.
- R2: In idle, a zero bit starts examination and aligns the group so that this zero is its third bit. If the group completes with no second zero (for example 11011), the block returns to idle without raising carrier.
- R3: A second zero bit within the aligned group raises `receiving` one clock after that zero bit is sampled.
- R4: `crs` equals `receiving` on every cycle.
- R5: If the first aligned group after carrier is not /J/ = 5'b11000 (the first bit received is the MSB), the block signals a false carrier: `receiving` drops and `rx_er` rises on the clock after the group completes.
- R6: If the second aligned group is not /K/ = 5'b10001, the block signals a false carrier in the same way.
- R7: `rx_er` stays high for exactly ERR_HOLD (default 5) clocks, after which the block is idle. Input bits during that hold, including zeros, start no new carrier.
- R8: In the receive state, the group /T/ = 5'b01101 followed directly by /R/ = 5'b00111 ends the stream. `receiving` drops on the clock after the /R/ group completes and `rx_er` stays low. A /R/ that does not directly follow /T/ does not end the stream.
- R9: In the receive state, a run of IDLE_RUN (default 10) consecutive one bits ends the stream with `rx_er` raised on the clock that samples the last one.
- R10: While `receiving` is high, `grp_valid` pulses for one clock exactly every 5 clocks. Each pulse shows the newly completed aligned group on `grp_data`, with the earliest bit in the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Descrambled code bit |
| crs | output | 1 | Carrier sense |
| rx_er | output | 1 | Receive error (false carrier or premature end) |
| receiving | output | 1 | Receive-in-progress flag |
| grp_valid | output | 1 | Aligned code-group strobe |
| grp_data | output | 5 | Last aligned code group, first bit in MSB |

## Verification
The assertions check on every cycle that carrier only rises after a zero bit, and that an error only begins after receiving was up. They also check that an error starting from the receive state follows a one bit, that a clean end of stream falls on a group boundary, that strobes never come back to back, and that idle follows the end of an error. Only the bench's scenarios show the exact group values that are accepted or refused, and the counted width of the error. The same goes for the position of the first and last receiving cycle relative to the stream, the five-clock strobe spacing, the /T/-then-/R/ ordering, and the fact that zeros during the error hold are ignored.

// File: rtl/pcs_crs_pkg.sv
package pcs_crs_pkg;
   localparam int GRP_W = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EXAM,
      ST_CARJ,
      ST_CARK,
      ST_RECV,
      ST_ERR
   } crs_state_t;

   localparam logic [GRP_W-1:0] SYM_J = 5'b11000;
   localparam logic [GRP_W-1:0] SYM_K = 5'b10001;
   localparam logic [GRP_W-1:0] SYM_T = 5'b01101;
   localparam logic [GRP_W-1:0] SYM_R = 5'b00111;
endpackage

// File: rtl/pcs_crs_align.sv
module pcs_crs_align #(
   parameter int GW   = 5,
   parameter int ZPOS = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rx_bit,
   input  logic          restart,
   input  logic          active,
   output logic          grp_stb,
   output logic [GW-1:0] grp_data
);
   localparam int PW = $clog2(GW);
   localparam logic [PW-1:0] PH_LAST = PW'(GW - 1);
   localparam logic [PW-1:0] PH_LOAD = PW'(ZPOS + 1);

   logic [PW-1:0] ph_q;
   logic [GW-1:0] sh_q;
   logic          stb_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= '0;
         sh_q  <= '1;
         stb_q <= 1'b0;
      end else begin
         sh_q  <= {sh_q[GW-2:0], rx_bit};
         stb_q <= active && (ph_q == PH_LAST);
         if (restart)
            ph_q <= PH_LOAD;
         else if (ph_q == PH_LAST)
            ph_q <= '0;
         else
            ph_q <= ph_q + 1'b1;
      end
   end

   assign grp_stb  = stb_q;
   assign grp_data = sh_q;

   // R10: group strobes are never adjacent
   p_stb_gap_r10: assert property (@(posedge clk) disable iff (rst)
      stb_q |=> !stb_q);
endmodule

// File: rtl/pcs_crs_runlen.sv
module pcs_crs_runlen #(
   parameter int RUN = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic rx_bit,
   output logic run_last
);
   localparam int RW = $clog2(RUN + 1);
   localparam logic [RW-1:0] CNT_MAX  = RW'(RUN);
   localparam logic [RW-1:0] CNT_LAST = RW'(RUN - 1);

   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (!rx_bit)
         cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assign run_last = (cnt_q >= CNT_LAST);
endmodule

// File: rtl/pcs_crs_fsm.sv
module pcs_crs_fsm
   import pcs_crs_pkg::*;
#(
   parameter int               GW       = 5,
   parameter int               ERR_HOLD = 5,
   parameter logic [GW-1:0]    CODE_J   = SYM_J,
   parameter logic [GW-1:0]    CODE_K   = SYM_K,
   parameter logic [GW-1:0]    CODE_T   = SYM_T,
   parameter logic [GW-1:0]    CODE_R   = SYM_R
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rx_bit,
   input  logic          grp_stb,
   input  logic [GW-1:0] grp_data,
   input  logic          run_last,
   output logic          restart,
   output logic          active,
   output logic          receiving,
   output logic          rx_er
);
   crs_state_t st_q, st_n;
   logic       t_seen_q, t_seen_n;
   logic       hold_done;

   generate
      if (ERR_HOLD > 1) begin : g_hold_cnt
         localparam int HW = $clog2(ERR_HOLD);
         localparam logic [HW-1:0] HOLD_LAST = HW'(ERR_HOLD - 1);
         logic [HW-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (rst || st_q != ST_ERR)
               hold_q <= '0;
            else
               hold_q <= hold_q + 1'b1;
         end
         assign hold_done = (hold_q == HOLD_LAST);
      end else begin : g_hold_one
         assign hold_done = 1'b1;
      end
   endgenerate

   always_comb begin
      st_n     = st_q;
      t_seen_n = t_seen_q;
      restart  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (!rx_bit) begin
            st_n    = ST_EXAM;
            restart = 1'b1;
         end
         ST_EXAM: begin
            if (grp_stb)
               st_n = ST_IDLE;
            else if (!rx_bit)
               st_n = ST_CARJ;
         end
         ST_CARJ: if (grp_stb)
            st_n = (grp_data == CODE_J) ? ST_CARK : ST_ERR;
         ST_CARK: if (grp_stb) begin
            st_n     = (grp_data == CODE_K) ? ST_RECV : ST_ERR;
            t_seen_n = 1'b0;
         end
         ST_RECV: begin
            if (rx_bit && run_last)
               st_n = ST_ERR;
            else if (grp_stb) begin
               if (t_seen_q && grp_data == CODE_R)
                  st_n = ST_IDLE;
               t_seen_n = (grp_data == CODE_T);
            end
         end
         ST_ERR: if (hold_done)
            st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         t_seen_q <= 1'b0;
      end else begin
         st_q     <= st_n;
         t_seen_q <= t_seen_n;
      end
   end

   assign active    = (st_q == ST_EXAM) || (st_q == ST_CARJ) ||
                      (st_q == ST_CARK) || (st_q == ST_RECV);
   assign receiving = (st_q == ST_CARJ) || (st_q == ST_CARK) || (st_q == ST_RECV);
   assign rx_er     = (st_q == ST_ERR);

   // R3: carrier only rises after a zero bit was sampled
   p_rise_on_zero_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(receiving) && !$past(rst) |-> !$past(rx_bit));
   // R5: an error only starts while a stream was being received
   p_err_after_rcv_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_er) && !$past(rst) |-> $past(receiving));
   // R8: a clean end of stream happens on a group boundary
   p_end_on_grp_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(receiving) && !rx_er && !$past(rst) |-> $past(grp_stb));
   // R9: an error out of the receive state follows a one bit
   p_prem_on_one_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_er) && $past(st_q == ST_RECV) && !$past(rst) |-> $past(rx_bit));
   // R7: the end of the error hold leaves the block idle
   p_hold_to_idle_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_er) && !$past(rst) |-> !receiving);
endmodule

// File: rtl/pcs_carrier_sense.sv
module pcs_carrier_sense
   import pcs_crs_pkg::*;
#(
   parameter int                 ERR_HOLD  = 5,
   parameter int                 IDLE_RUN  = 10,
   parameter int                 ZERO_POS  = 2,
   parameter logic [GRP_W-1:0]   CODE_J    = SYM_J,
   parameter logic [GRP_W-1:0]   CODE_K    = SYM_K,
   parameter logic [GRP_W-1:0]   CODE_T    = SYM_T,
   parameter logic [GRP_W-1:0]   CODE_R    = SYM_R
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_bit,
   output logic             crs,
   output logic             rx_er,
   output logic             receiving,
   output logic             grp_valid,
   output logic [GRP_W-1:0] grp_data
);
   initial begin
      assert (ERR_HOLD >= 1) else $error("ERR_HOLD must be at least 1");
      assert (IDLE_RUN >= 2) else $error("IDLE_RUN must be at least 2");
      assert (ZERO_POS >= 0 && ZERO_POS <= GRP_W - 2)
         else $error("ZERO_POS out of range");
      assert (CODE_J[GRP_W-1-ZERO_POS] == 1'b0)
         else $error("start code must hold a zero at ZERO_POS");
   end

   logic             restart, active, grp_stb, run_last, rcv;
   logic [GRP_W-1:0] grp;

   pcs_crs_align #(.GW(GRP_W), .ZPOS(ZERO_POS)) u_align (
      .clk(clk), .rst(rst), .rx_bit(rx_bit),
      .restart(restart), .active(active),
      .grp_stb(grp_stb), .grp_data(grp)
   );

   pcs_crs_runlen #(.RUN(IDLE_RUN)) u_run (
      .clk(clk), .rst(rst), .rx_bit(rx_bit), .run_last(run_last)
   );

   pcs_crs_fsm #(
      .GW(GRP_W), .ERR_HOLD(ERR_HOLD),
      .CODE_J(CODE_J), .CODE_K(CODE_K), .CODE_T(CODE_T), .CODE_R(CODE_R)
   ) u_fsm (
      .clk(clk), .rst(rst), .rx_bit(rx_bit),
      .grp_stb(grp_stb), .grp_data(grp), .run_last(run_last),
      .restart(restart), .active(active),
      .receiving(rcv), .rx_er(rx_er)
   );

   assign crs       = rcv;
   assign receiving = rcv;
   assign grp_valid = grp_stb && rcv;
   assign grp_data  = grp;
endmodule

// File: tb/pcs_carrier_sense_test.sv
`timescale 1ns/1ps
module pcs_carrier_sense_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_bit = 1'b1;
   logic       crs, rx_er, receiving, grp_valid;
   logic [4:0] grp_data;

   always #2 clk = ~clk;

   pcs_carrier_sense uut (
      .clk(clk), .rst(rst), .rx_bit(rx_bit),
      .crs(crs), .rx_er(rx_er), .receiving(receiving),
      .grp_valid(grp_valid), .grp_data(grp_data)
   );

   typedef struct packed {
      logic [39:0] bits;
      logic [5:0]  len;
      logic [5:0]  n_rcv;
      logic [3:0]  n_er;
      logic [3:0]  n_stb;
      logic [7:0]  first_rcv;
      logic [7:0]  last_rcv;
      logic [4:0]  first_grp;
   } vec_t;

   // stream = 8 idle ones, then the frame, then 24 ones; index i = sample after the i-th bit
   localparam vec_t TBL [8] = '{
      '{bits: {5'b11000, 5'b10001, 5'b01010, 5'b11110, 5'b01101, 5'b00111, 10'd0},
        len: 6'd30, n_rcv: 6'd27, n_er: 4'd0, n_stb: 4'd6, first_rcv: 8'd11, last_rcv: 8'd37, first_grp: 5'b11000},
      '{bits: {5'b11010, 35'd0},
        len: 6'd5, n_rcv: 6'd1, n_er: 4'd5, n_stb: 4'd1, first_rcv: 8'd12, last_rcv: 8'd12, first_grp: 5'b11010},
      '{bits: {5'b11011, 35'd0},
        len: 6'd5, n_rcv: 6'd0, n_er: 4'd0, n_stb: 4'd0, first_rcv: 8'd255, last_rcv: 8'd0, first_grp: 5'b00000},
      '{bits: {5'b11000, 5'b10101, 30'd0},
        len: 6'd10, n_rcv: 6'd7, n_er: 4'd5, n_stb: 4'd2, first_rcv: 8'd11, last_rcv: 8'd17, first_grp: 5'b11000},
      '{bits: {5'b11000, 5'b10001, 5'b01010, 25'd0},
        len: 6'd15, n_rcv: 6'd21, n_er: 4'd5, n_stb: 4'd4, first_rcv: 8'd11, last_rcv: 8'd31, first_grp: 5'b11000},
      '{bits: {5'b11000, 5'b10001, 5'b01101, 5'b01010, 5'b00111, 15'd0},
        len: 6'd25, n_rcv: 6'd28, n_er: 4'd5, n_stb: 4'd6, first_rcv: 8'd11, last_rcv: 8'd38, first_grp: 5'b11000},
      '{bits: {5'b11001, 35'd0},
        len: 6'd5, n_rcv: 6'd2, n_er: 4'd5, n_stb: 4'd1, first_rcv: 8'd11, last_rcv: 8'd12, first_grp: 5'b11001},
      '{bits: {5'b11010, 6'b000000, 29'd0},
        len: 6'd11, n_rcv: 6'd1, n_er: 4'd5, n_stb: 4'd1, first_rcv: 8'd12, last_rcv: 8'd12, first_grp: 5'b11010}
   };

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;
   int s_rcv, s_er, s_stb, s_first, s_last, s_grp, s_mism, s_gap, s_prev;

   function automatic string vec_tag(int v);
      case (v)
         0: return "R8";  1: return "R5";  2: return "R2";  3: return "R6";
         4: return "R9";  5: return "R8";  6: return "R5";  default: return "R7";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_stream(input logic [39:0] bits, input int len);
      s_rcv = 0; s_er = 0; s_stb = 0; s_first = 255; s_last = 0;
      s_grp = 0; s_mism = 0; s_gap = 0; s_prev = -1;
      for (int i = 0; i < 8 + len + 24; i++) begin
         rx_bit = (i < 8 || i >= 8 + len) ? 1'b1 : bits[39 - (i - 8)];
         @(negedge clk);
         if (receiving) begin
            s_rcv++;
            if (s_first == 255) s_first = i;
            s_last = i;
         end
         if (rx_er) s_er++;
         if (crs != receiving) s_mism++;
         if (grp_valid) begin
            if (s_stb == 0) s_grp = grp_data;
            if (s_prev >= 0 && i - s_prev != 5) s_gap++;
            s_prev = i;
            s_stb++;
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!crs && !receiving && !rx_er && !grp_valid, "R1", "outputs low in reset",
          {crs, receiving, rx_er, grp_valid}, 0);
      chk(grp_data == 5'b11111, "R1", "grp_data in reset", grp_data, 31);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         run_stream(TBL[v].bits, int'(TBL[v].len));
         chk(s_rcv == int'(TBL[v].n_rcv), vec_tag(v), "receiving cycles", s_rcv, int'(TBL[v].n_rcv));
         chk(s_er == int'(TBL[v].n_er), vec_tag(v), "rx_er cycles (R7 width)", s_er, int'(TBL[v].n_er));
         chk(s_stb == int'(TBL[v].n_stb), "R10", "strobe count", s_stb, int'(TBL[v].n_stb));
         chk(s_first == int'(TBL[v].first_rcv), "R3", "first receiving index", s_first, int'(TBL[v].first_rcv));
         chk(s_last == int'(TBL[v].last_rcv), vec_tag(v), "last receiving index", s_last, int'(TBL[v].last_rcv));
         chk(s_grp == int'(TBL[v].first_grp), "R10", "first group value", s_grp, int'(TBL[v].first_grp));
         chk(s_gap == 0, "R10", "strobe spacing errors", s_gap, 0);
         chk(s_mism == 0, "R4", "crs/receiving mismatches", s_mism, 0);
         chk(!receiving && !rx_er, vec_tag(v), "idle after stream",
             {receiving, rx_er}, 0);
      end

      // R1: reset taken in the middle of a stream
      for (int i = 0; i < 20; i++) begin
         rx_bit = (i < 5)  ? TBL[0].bits[39 - i] :
                  (i < 10) ? TBL[0].bits[39 - i] :
                  (i < 15) ? TBL[0].bits[39 - i] : TBL[0].bits[39 - i];
         @(negedge clk);
      end
      chk(receiving == 1'b1, "R3", "receiving mid-stream", receiving, 1);
      rx_bit = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      chk(!crs && !receiving && !rx_er && !grp_valid, "R1", "outputs after mid-stream reset",
          {crs, receiving, rx_er, grp_valid}, 0);
      chk(grp_data == 5'b11111, "R1", "grp_data after mid-stream reset", grp_data, 31);
      rst = 1'b0;
      @(negedge clk);
      run_stream(TBL[0].bits, int'(TBL[0].len));
      chk(s_rcv == 27, "R1", "stream after reset receiving cycles", s_rcv, 27);
      chk(s_first == 11, "R1", "stream after reset first index", s_first, 11);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule